// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Collision and Mode-Fault Detection

This block moves one byte at a time over an SPI link in either direction. It can run as the master: it drives the serial clock and the outgoing data line, and it advances one serial-clock edge on each pulse of an external bit-rate tick. It can also run as a slave: it follows an external serial clock while its select input is held low. Software reaches it through a small register port. A control register holds the interrupt enable, the master selection and the block enable. A status register holds three sticky flags. The data register is written to send a byte and read to get the last byte received.

Two error conditions are flagged. A write collision is a write to the data register while a byte is on the wire. That write is dropped and the byte in flight carries on. A mode fault is the select input being pulled low by another device while this block is enabled as master. The fault aborts the transfer, clears the enable and master bits, and keeps them cleared until software has read the status register and then writes the control register again. A read of the status register clears every flag it returns. The interrupt output is high while interrupts are enabled and any flag is set.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0x00, and `sck_o`, `mosi_o` and `irq_o` are low.
- R2: In master mode, control register bit 1 = 1 and bit 0 = 1. Writing the data register (address 2) sends the byte MSB first in SPI mode 0. `sck_o` idles low and toggles once per `bit_tick`, so a byte takes 16 ticks. `miso_i` is sampled on each rising `sck_o`. At the end, a read of address 2 returns the byte received.
- R3: Status bit 7 (transfer done) sets when the eighth bit has been shifted. A status read clears it.
- R4: Status bit 5 (write collision) sets when the data register is written while a byte is being transferred. That write is discarded and the byte in flight is sent unchanged.
- R5: A status read that returns the collision flag as 1 clears it, so the next status read returns 0.
- R6: Status bit 4 (mode fault) sets when `ss_n_i` is low while the enable and master bits are both 1. The fault clears both bits, aborts any transfer with `sck_o` returned low, and produces no done flag.
- R7: While the mode-fault flag is set, control-register writes cannot set the enable or master bits. After a status read has cleared the flag, a control-register write can set them.
- R8: `irq_o` equals control bit 7 (interrupt enable) ANDed with the OR of the three status flags. It falls once a status read has cleared the flags.
- R9: In slave mode, bit 1 = 0 and bit 0 = 1. While `ss_n_i` is low, the block samples `mosi_i` on rising `sck_i` and presents the byte loaded earlier on `miso_o`, MSB first, changing it after falling `sck_i`. After eight bits it sets the done flag and returns the received byte at address 2.
- R10: A data-register write while the block is disabled starts no transfer: `sck_o` does not toggle and no status flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Bit-rate tick; in master mode each pulse advances one serial-clock edge |
| reg_sel | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a status read clears the flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| sck_o | output | 1 | Serial clock out (master mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| ss_n_i | input | 1 | Active-low select; selects the block in slave mode, raises a fault in master mode |
| sck_i | input | 1 | Serial clock in (slave mode) |
| mosi_i | input | 1 | Serial data in (slave mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a mode fault that lands in the middle of a master byte while software then tries to re-enable the block. That needs a running transfer, `ss_n_i` pulled low part way through the bit sequence, and a control write made before the flag is cleared. The stimulus starts a master byte, drops `ss_n_i` after a fixed number of ticks, and writes the control register twice: once while the flag is still set and once after a status read and the release of select. A collision is reached in the same way, by a second data write timed inside the 16-tick window in both master and slave mode. Random bytes and tick spacings cover the ordinary master path.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int BYTE_W = 8;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control bit positions
    localparam int CTRL_IRQ_BIT = 7;
    localparam int CTRL_MST_BIT = 1;
    localparam int CTRL_EN_BIT  = 0;

    // status bit positions
    localparam int ST_DONE_BIT = 7;
    localparam int ST_WCOL_BIT = 5;
    localparam int ST_MODF_BIT = 4;

    typedef struct packed {
        logic irq_en;
        logic master;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic wcol;
        logic modf;
    } flags_t;

    function automatic ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] v);
        ctrl_t c;
        c.irq_en = v[CTRL_IRQ_BIT];
        c.master = v[CTRL_MST_BIT];
        c.enable = v[CTRL_EN_BIT];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[CTRL_IRQ_BIT] = c.irq_en;
        v[CTRL_MST_BIT] = c.master;
        v[CTRL_EN_BIT]  = c.enable;
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_stat(input flags_t f);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[ST_DONE_BIT] = f.done;
        v[ST_WCOL_BIT] = f.wcol;
        v[ST_MODF_BIT] = f.modf;
        return v;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load_req,
    input  logic [DW-1:0] tx_byte,
    input  logic          miso,
    input  logic          abort,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          samp, sck_q, busy_q, done_q;
    logic [DW-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0; cnt <= '0; samp <= 1'b0; sck_q <= 1'b0;
            busy_q <= 1'b0; done_q <= 1'b0; rx_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
                sck_q  <= 1'b0;
                cnt    <= '0;
            end else if (!busy_q) begin
                if (load_req) begin
                    sh     <= tx_byte;
                    busy_q <= 1'b1;
                    cnt    <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (tick) begin
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    samp  <= miso;
                end else begin
                    sck_q <= 1'b0;
                    sh    <= {sh[DW-2:0], samp};
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        rx_q   <= {sh[DW-2:0], samp};
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign sck     = sck_q;
    assign mosi    = busy_q ? sh[DW-1] : 1'b0;
    assign done    = done_q;
    assign rx_byte = rx_q;

    // serial clock idles low outside a transfer
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sck_q);

    // a colliding write leaves the byte in flight untouched
    assert_collide_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && load_req && !tick) |=> ($stable(sh) && busy_q));

    // abort ends the transfer
    assert_abort_stops_R6: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy_q && !sck_q && !done_q));

    // done only after a transfer ended
    assert_done_end_R3: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);
endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          ss_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic          load,
    input  logic [DW-1:0] tx_byte,
    output logic          busy,
    output logic          miso,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic          sel, sck_prev, rise, fall, samp, done_q;
    logic [DW-1:0] sh, rx_q;
    logic [CW-1:0] cnt;

    assign sel  = active && !ss_n;
    assign rise = sck && !sck_prev;
    assign fall = !sck && sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0; samp <= 1'b0; done_q <= 1'b0;
            sh <= '0; rx_q <= '0; cnt <= '0;
        end else begin
            done_q   <= 1'b0;
            sck_prev <= sck;
            if (!sel) begin
                cnt <= '0;
                if (load) sh <= tx_byte;
            end else begin
                if (rise) samp <= mosi;
                if (fall) begin
                    sh  <= {sh[DW-2:0], samp};
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        done_q <= 1'b1;
                        rx_q   <= {sh[DW-2:0], samp};
                    end
                end
            end
        end
    end

    assign busy    = sel;
    assign miso    = sel ? sh[DW-1] : 1'b0;
    assign done    = done_q;
    assign rx_byte = rx_q;

    // bit counter restarts whenever the block is deselected
    assert_slave_restart_R9: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (cnt == '0));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_byte_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_ctrl,
    input  ctrl_t  wr_val,
    input  logic   rd_stat,
    input  logic   set_done,
    input  logic   set_wcol,
    input  logic   set_modf,
    output ctrl_t  ctrl,
    output flags_t flags,
    output logic   irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            flags <= '0;
        end else begin
            if (wr_ctrl) ctrl.irq_en <= wr_val.irq_en;
            if (set_modf) begin
                ctrl.master <= 1'b0;
                ctrl.enable <= 1'b0;
            end else if (wr_ctrl) begin
                ctrl.master <= wr_val.master && !flags.modf;
                ctrl.enable <= wr_val.enable && !flags.modf;
            end
            flags.done <= (flags.done && !rd_stat) || set_done;
            flags.wcol <= (flags.wcol && !rd_stat) || set_wcol;
            flags.modf <= (flags.modf && !rd_stat) || set_modf;
        end
    end

    assign irq = ctrl.irq_en && (flags.done || flags.wcol || flags.modf);

    assert_fault_drops_R6: assert property (@(posedge clk) disable iff (rst)
        set_modf |=> (!ctrl.enable && !ctrl.master && flags.modf));

    assert_fault_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (flags.modf && wr_ctrl) |=> (!ctrl.enable && !ctrl.master));

    assert_wcol_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && flags.wcol && !set_wcol) |=> !flags.wcol);

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !set_done && !set_wcol && !set_modf) |=> !irq);
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
    import spi_byte_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              ss_n_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              irq_o
);
    logic ss_n_s, sck_s, mosi_s;

    spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_sync_ss (
        .clk(clk), .rst(rst), .d(ss_n_i), .q(ss_n_s));
    spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b00)) u_sync_bus (
        .clk(clk), .rst(rst), .d({sck_i, mosi_i}), .q({sck_s, mosi_s}));

    ctrl_t  ctrl;
    flags_t flags;

    logic wr_ctrl, wr_dat, rd_stat;
    logic fault, m_busy, s_busy, busy_any;
    logic m_load, s_load, m_done, s_done;
    logic [BYTE_W-1:0] m_rx, s_rx, rx_q;

    assign wr_ctrl  = wr_en && (reg_sel == ADDR_CTRL);
    assign wr_dat   = wr_en && (reg_sel == ADDR_DATA);
    assign rd_stat  = rd_en && (reg_sel == ADDR_STAT);
    assign busy_any = m_busy || s_busy;
    assign fault    = ctrl.enable && ctrl.master && !ss_n_s;
    assign m_load   = wr_dat && ctrl.enable && ctrl.master && !fault;
    assign s_load   = wr_dat && ctrl.enable && !ctrl.master;

    spi_master_eng #(.DW(BYTE_W)) u_master (
        .clk(clk), .rst(rst), .tick(bit_tick), .load_req(m_load),
        .tx_byte(wr_data), .miso(miso_i), .abort(fault), .busy(m_busy),
        .sck(sck_o), .mosi(mosi_o), .done(m_done), .rx_byte(m_rx));

    spi_slave_eng #(.DW(BYTE_W)) u_slave (
        .clk(clk), .rst(rst), .active(ctrl.enable && !ctrl.master),
        .ss_n(ss_n_s), .sck(sck_s), .mosi(mosi_s), .load(s_load),
        .tx_byte(wr_data), .busy(s_busy), .miso(miso_o), .done(s_done),
        .rx_byte(s_rx));

    spi_regs u_regs (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_val(unpack_ctrl(wr_data)),
        .rd_stat(rd_stat), .set_done(m_done || s_done),
        .set_wcol(wr_dat && busy_any), .set_modf(fault),
        .ctrl(ctrl), .flags(flags), .irq(irq_o));

    always_ff @(posedge clk) begin
        if (rst)         rx_q <= '0;
        else if (m_done) rx_q <= m_rx;
        else if (s_done) rx_q <= s_rx;
    end

    always_comb begin
        case (reg_sel)
            ADDR_CTRL: rd_data = pack_ctrl(ctrl);
            ADDR_STAT: rd_data = pack_stat(flags);
            ADDR_DATA: rd_data = rx_q;
            default:   rd_data = '0;
        endcase
    end

    // a disabled block never drives a serial clock
    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !m_busy) |=> !sck_o);
endmodule

// File: tb/spi_byte_ctrl_test.sv
`timescale 1ns/1ps
module spi_byte_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sck_o, mosi_o, miso_o, irq_o;
    logic       ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0;
    logic       miso_i;

    int checks = 0, failures = 0;
    bit finished = 0;

    spi_byte_ctrl uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .reg_sel(reg_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_i(ss_n_i),
        .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o), .irq_o(irq_o));

    always #4 clk = ~clk;

    // tick generator
    int tick_div = 1;
    int tick_cnt = 0;
    always @(negedge clk) begin
        if (tick_cnt >= tick_div - 1) begin bit_tick <= 1'b1; tick_cnt <= 0; end
        else begin bit_tick <= 1'b0; tick_cnt <= tick_cnt + 1; end
    end

    // bench slave for master mode
    logic [7:0] slv_byte = 8'h00;
    int         slv_idx = 0;
    logic [7:0] mosi_got = 8'h00;
    int         sck_edges = 0;
    assign miso_i = (slv_idx < 8) ? slv_byte[7 - slv_idx] : 1'b0;
    always @(negedge sck_o) slv_idx <= slv_idx + 1;
    always @(posedge sck_o) begin
        mosi_got  <= {mosi_got[6:0], mosi_o};
        sck_edges <= sck_edges + 1;
    end

    function automatic logic [7:0] exp_status(bit done, bit wcol, bit modf);
        return {done, 1'b0, wcol, modf, 4'b0};
    endfunction

    function automatic logic [7:0] exp_ctrl(bit ie, bit mst, bit en);
        return {ie, 5'b0, mst, en};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_sel = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_xfer(logic [7:0] tx, logic [7:0] sb, int div, bit ie);
        logic [7:0] v;
        tick_div = div;
        slv_byte = sb; slv_idx = 0; mosi_got = 8'h00;
        write_reg(2'd2, tx);
        wait_clk(16 * div + 12);
        chk("R2 mosi byte", mosi_got, tx);
        chk("R8 irq level", {7'b0, irq_o}, {7'b0, ie});
        read_reg(2'd1, v);
        chk("R3 done flag", v, exp_status(1, 0, 0));
        read_reg(2'd2, v);
        chk("R2 rx byte", v, sb);
        chk("R8 irq after clear", {7'b0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h00C0FFEE));
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        read_reg(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
        read_reg(2'd1, v); chk("R1 status reset", v, 8'h00);
        chk("R1 outputs low", {5'b0, sck_o, mosi_o, irq_o}, 8'h00);

        // R10 write while disabled
        write_reg(2'd2, 8'h77);
        wait_clk(40);
        chk("R10 no sck edges", 8'(sck_edges), 8'h00);
        read_reg(2'd1, v); chk("R10 no flags", v, 8'h00);

        // R2 R3 R8 directed master transfers
        write_reg(2'd0, exp_ctrl(1, 1, 1));
        read_reg(2'd0, v); chk("R2 ctrl readback", v, 8'h83);
        master_xfer(8'hA5, 8'h3C, 1, 1);
        master_xfer(8'h80, 8'h01, 3, 1);

        // R8 interrupt disabled
        write_reg(2'd0, exp_ctrl(0, 1, 1));
        master_xfer(8'hFF, 8'h00, 2, 0);

        // R4 R5 collision in master mode
        write_reg(2'd0, exp_ctrl(1, 1, 1));
        tick_div = 2; slv_byte = 8'h96; slv_idx = 0; mosi_got = 8'h00;
        write_reg(2'd2, 8'h4B);
        wait_clk(10);
        write_reg(2'd2, 8'hE1);
        wait_clk(16 * 2 + 12);
        chk("R4 byte in flight kept", mosi_got, 8'h4B);
        read_reg(2'd1, v); chk("R4 wcol and done", v, exp_status(1, 1, 0));
        read_reg(2'd1, v); chk("R5 wcol cleared", v, 8'h00);
        read_reg(2'd2, v); chk("R4 rx after collision", v, 8'h96);

        // R6 R7 mode fault mid-transfer
        tick_div = 3; slv_byte = 8'h55; slv_idx = 0;
        write_reg(2'd2, 8'hC3);
        wait_clk(20);
        ss_n_i = 1'b0;
        wait_clk(6);
        chk("R6 sck low after abort", {7'b0, sck_o}, 8'h00);
        chk("R8 irq on fault", {7'b0, irq_o}, 8'h01);
        read_reg(2'd0, v); chk("R6 enable and master cleared", v, exp_ctrl(1, 0, 0));
        write_reg(2'd0, exp_ctrl(1, 1, 1));
        read_reg(2'd0, v); chk("R7 locked while flagged", v, exp_ctrl(1, 0, 0));
        wait_clk(60);
        read_reg(2'd1, v); chk("R6 fault flag only", v, exp_status(0, 0, 1));
        read_reg(2'd1, v); chk("R6 fault flag cleared", v, 8'h00);
        ss_n_i = 1'b1;
        wait_clk(4);
        write_reg(2'd0, exp_ctrl(1, 1, 1));
        read_reg(2'd0, v); chk("R7 restore after clear", v, exp_ctrl(1, 1, 1));

        // R9 slave mode with a collision
        begin
            logic [7:0] stx, srx, seen;
            stx = 8'h6D; srx = 8'hB2; seen = 8'h00;
            write_reg(2'd0, exp_ctrl(1, 0, 1));
            write_reg(2'd2, stx);
            ss_n_i = 1'b0;
            wait_clk(6);
            for (int i = 0; i < 8; i++) begin
                mosi_i = srx[7 - i];
                wait_clk(6);
                seen = {seen[6:0], miso_o};
                if (i == 3) begin
                    reg_sel = 2'd2; wr_data = 8'h11; wr_en = 1'b1;
                    @(negedge clk); wr_en = 1'b0;
                end
                sck_i = 1'b1;
                wait_clk(6);
                sck_i = 1'b0;
            end
            wait_clk(8);
            chk("R9 slave miso byte", seen, stx);
            chk("R9 irq on slave done", {7'b0, irq_o}, 8'h01);
            read_reg(2'd1, v); chk("R9 R4 slave status", v, exp_status(1, 1, 0));
            read_reg(2'd2, v); chk("R9 slave rx byte", v, srx);
            ss_n_i = 1'b1;
            wait_clk(4);
        end

        // R2 R3 random master transfers
        write_reg(2'd0, exp_ctrl(1, 1, 1));
        for (int n = 0; n < 20; n++) begin
            logic [7:0] t, s;
            int d;
            t = 8'($urandom);
            s = 8'($urandom);
            d = 1 + int'($urandom % 4);
            master_xfer(t, s, d, 1);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule